// File: doc/BRIEF.md
# Priority interrupt source selector

This block picks, for a single target context, the one interrupt source that should be presented next. Every source slot supplies three things: a pending flag, a claimed flag and a 4-bit priority value held by the enclosing controller. The selector reduces all slots in a single combinational pass. It returns the winning source number, the priority of that source and a flag that says whether any winner exists.

The winner's priority is then compared with the context's threshold to form the interrupt request line for that context. Storage for priorities, pending, claimed and threshold state stays outside this block, as do the bus decode and the claim/complete sequencing. The controller instantiates one selector per context.

The reduction is a balanced binary tree of two-input comparators. The logic depth therefore grows with the logarithm of the slot count. Slot 0 is reserved and never wins. Slots at or above the configured live source count are tied off.

Top module: `prio_sel_top`

## Requirements
- R1: Source number 0 is never selected, even when pending with priority 15; when no source is eligible the outputs are win_valid_o=0, win_id_o=0, win_prio_o=0.
- R2: A source is eligible only when its pending bit is 1 and its claimed bit is 0.
- R3: Among eligible sources the one with the numerically largest priority wins.
- R4: When several eligible sources share the largest priority, the one with the smallest source number wins.
- R5: A source whose priority field is 0 is never eligible.
- R6: Slots whose number is at or above NUM_SRC (default 28, slot width MAX_SRC default 32) are ignored whatever their inputs.
- R7: irq_o is 1 exactly when a winner exists and its priority is strictly greater than threshold_i.
- R8: win_prio_o equals the priority field of the winning source; source s takes its priority from prio_i[4*s+3:4*s].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pending_i | input | MAX_SRC | Pending flag per source slot |
| claimed_i | input | MAX_SRC | Claimed (in service) flag per source slot |
| prio_i | input | 4*MAX_SRC | Priority per slot, slot s at bits 4*s+3:4*s |
| threshold_i | input | 4 | Context priority threshold |
| win_id_o | output | clog2(MAX_SRC) | Winning source number, 0 when none |
| win_prio_o | output | 4 | Priority of the winner, 0 when none |
| win_valid_o | output | 1 | A winner exists |
| irq_o | output | 1 | Interrupt request for the context |

## Verification
The hardest case to reach from the ports is a priority tie whose two members sit in different subtrees of the comparator tree. Only the top-level node then resolves the tie, while a higher-priority source that is claimed or out of range must stay invisible. Directed vectors place equal priorities at slots 5 and 9, and at slots 1 and 27. They also park higher priorities on slot 0, on claimed slots and on slots 28 to 31. Random vectors with few distinct priority values then create many further multi-way ties across the tree.

// File: rtl/prio_sel_pkg.sv
package prio_sel_pkg;
  localparam int PRIO_W   = 4;
  localparam int ID_W_MAX = 10;

  typedef struct packed {
    logic                valid;
    logic [ID_W_MAX-1:0] id;
    logic [PRIO_W-1:0]   prio;
  } cand_t;
endpackage

// File: rtl/prio_sel_leaf.sv
module prio_sel_leaf
  import prio_sel_pkg::*;
#(
  parameter int IDX = 1
) (
  input  logic              pending_i,
  input  logic              claimed_i,
  input  logic [PRIO_W-1:0] prio_i,
  output cand_t             cand_o
);
  logic eligible;

  assign eligible = pending_i & ~claimed_i & (prio_i != '0);

  always_comb begin
    cand_o       = '0;
    cand_o.valid = eligible;
    if (eligible) begin
      cand_o.id   = ID_W_MAX'(IDX);
      cand_o.prio = prio_i;
    end
  end

  always_comb begin
    a_r2_eligible: assert (!cand_o.valid || (pending_i && !claimed_i))
      else $error("leaf %0d valid while not pending or claimed", IDX);
    a_r5_zero_prio: assert (!cand_o.valid || cand_o.prio != '0)
      else $error("leaf %0d valid with priority 0", IDX);
  end
endmodule

// File: rtl/prio_sel_node.sv
module prio_sel_node
  import prio_sel_pkg::*;
(
  input  cand_t lo_i,
  input  cand_t hi_i,
  output cand_t win_o
);
  logic take_hi;

  // hi side holds larger IDs: it wins only with strictly greater priority
  assign take_hi = hi_i.valid && (!lo_i.valid || (hi_i.prio > lo_i.prio));
  assign win_o   = take_hi ? hi_i : lo_i;

  always_comb begin
    a_r4_tie_low: assert (!(lo_i.valid && hi_i.valid && lo_i.prio == hi_i.prio)
                          || win_o.id == lo_i.id)
      else $error("tie not resolved to lower id");
    a_r3_max_prio: assert ((!lo_i.valid || win_o.prio >= lo_i.prio) &&
                           (!hi_i.valid || win_o.prio >= hi_i.prio))
      else $error("node output below an input priority");
    a_r3_valid_or: assert (win_o.valid == (lo_i.valid || hi_i.valid))
      else $error("node valid mismatch");
  end
endmodule

// File: rtl/prio_sel_tree.sv
module prio_sel_tree
  import prio_sel_pkg::*;
#(
  parameter int LEAVES = 32
) (
  input  cand_t leaf_i [LEAVES],
  output cand_t root_o
);
  localparam int NODES = 2 * LEAVES - 1;

  cand_t node [NODES];

  for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
    assign node[LEAVES - 1 + l] = leaf_i[l];
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    prio_sel_node u_node (
      .lo_i  (node[2 * n + 1]),
      .hi_i  (node[2 * n + 2]),
      .win_o (node[n])
    );
  end

  assign root_o = node[0];
endmodule

// File: rtl/prio_sel_top.sv
module prio_sel_top
  import prio_sel_pkg::*;
#(
  parameter int MAX_SRC = 32,
  parameter int NUM_SRC = 28,
  localparam int ID_W   = $clog2(MAX_SRC)
) (
  input  logic [MAX_SRC-1:0]        pending_i,
  input  logic [MAX_SRC-1:0]        claimed_i,
  input  logic [MAX_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         threshold_i,
  output logic [ID_W-1:0]           win_id_o,
  output logic [PRIO_W-1:0]         win_prio_o,
  output logic                      win_valid_o,
  output logic                      irq_o
);
  localparam int LEAVES = 1 << ID_W;

  cand_t leaf_c [LEAVES];
  cand_t root;

  for (genvar s = 0; s < LEAVES; s++) begin : g_slot
    if (s >= MAX_SRC) begin : g_pad
      assign leaf_c[s] = '0;
    end else if (s == 0 || s >= NUM_SRC) begin : g_off
      logic unused_bits;
      assign unused_bits = ^{pending_i[s], claimed_i[s], prio_i[s*PRIO_W +: PRIO_W]};
      assign leaf_c[s]   = '0;
    end else begin : g_live
      prio_sel_leaf #(.IDX(s)) u_leaf (
        .pending_i (pending_i[s]),
        .claimed_i (claimed_i[s]),
        .prio_i    (prio_i[s*PRIO_W +: PRIO_W]),
        .cand_o    (leaf_c[s])
      );
    end
  end

  prio_sel_tree #(.LEAVES(LEAVES)) u_tree (
    .leaf_i (leaf_c),
    .root_o (root)
  );

  if (ID_W < ID_W_MAX) begin : g_id_hi
    logic unused_id_hi;
    assign unused_id_hi = ^root.id[ID_W_MAX-1:ID_W];
  end

  assign win_valid_o = root.valid;
  assign win_id_o    = root.id[ID_W-1:0];
  assign win_prio_o  = root.prio;
  assign irq_o       = root.valid && (root.prio > threshold_i);

  always_comb begin
    a_r1_none_zero: assert (win_valid_o || (win_id_o == '0 && win_prio_o == '0))
      else $error("no winner but id/prio nonzero");
    a_r6_range: assert (!win_valid_o || (win_id_o != '0 && int'(win_id_o) < NUM_SRC))
      else $error("winner id %0d outside live range", win_id_o);
    a_r8_prio_match: assert (!win_valid_o ||
                             win_prio_o == prio_i[int'(win_id_o)*PRIO_W +: PRIO_W])
      else $error("winner priority does not match its slot");
    a_r7_irq_gate: assert (!irq_o || (win_valid_o && win_prio_o > threshold_i))
      else $error("irq without qualifying winner");
  end
endmodule

// File: tb/tb_prio_sel_top.sv
module tb_prio_sel_top;
  localparam int MAX_SRC = 32;
  localparam int NUM_SRC = 28;
  localparam int ID_W    = $clog2(MAX_SRC);
  localparam int PW      = 4;

  typedef struct {
    int    id;
    int    prio;
    bit    valid;
    bit    irq;
    string req;
  } exp_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [MAX_SRC-1:0]    pending_i   = '0;
  logic [MAX_SRC-1:0]    claimed_i   = '0;
  logic [MAX_SRC*PW-1:0] prio_i      = '0;
  logic [PW-1:0]         threshold_i = '0;
  logic [ID_W-1:0]       win_id_o;
  logic [PW-1:0]         win_prio_o;
  logic                  win_valid_o;
  logic                  irq_o;

  prio_sel_top #(.MAX_SRC(MAX_SRC), .NUM_SRC(NUM_SRC)) dut (
    .pending_i, .claimed_i, .prio_i, .threshold_i,
    .win_id_o, .win_prio_o, .win_valid_o, .irq_o
  );

  logic [MAX_SRC-1:0]    st_pend = '0;
  logic [MAX_SRC-1:0]    st_clm  = '0;
  logic [MAX_SRC*PW-1:0] st_prio = '0;
  logic [PW-1:0]         st_thr  = '0;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;

  function automatic exp_t model(string req);
    exp_t e;
    int   p;
    e.id = 0; e.prio = 0; e.valid = 0; e.irq = 0; e.req = req;
    for (int i = 1; i < NUM_SRC; i++) begin
      p = int'(st_prio[i*PW +: PW]);
      if (st_pend[i] && !st_clm[i] && p != 0 && (!e.valid || p > e.prio)) begin
        e.id = i; e.prio = p; e.valid = 1;
      end
    end
    e.irq = e.valid && (e.prio > int'(st_thr));
    return e;
  endfunction

  task automatic clear_all();
    st_pend = '0; st_clm = '0; st_prio = '0; st_thr = '0;
  endtask

  task automatic src(int id, int p, bit pend, bit clm);
    st_pend[id] = pend;
    st_clm[id]  = clm;
    st_prio[id*PW +: PW] = PW'(p);
  endtask

  task automatic send(string req);
    @(posedge clk);
    pending_i   <= st_pend;
    claimed_i   <= st_clm;
    prio_i      <= st_prio;
    threshold_i <= st_thr;
    q.push_back(model(req));
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (int'(win_id_o) != e.id || int'(win_prio_o) != e.prio ||
          win_valid_o != e.valid || irq_o != e.irq) begin
        errors++;
        $display("FAIL %s: got id=%0d prio=%0d valid=%0d irq=%0d exp id=%0d prio=%0d valid=%0d irq=%0d",
                 e.req, win_id_o, win_prio_o, win_valid_o, irq_o,
                 e.id, e.prio, e.valid, e.irq);
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: idle state, nothing pending
    clear_all(); send("R1_idle");
    // R1: slot 0 pending at top priority never wins
    src(0, 15, 1, 0); send("R1_slot0");
    // R8: single source reports its own priority
    src(7, 9, 1, 0); send("R8_single");
    // R2: claimed source masked, next one wins
    clear_all(); src(4, 12, 1, 1); src(20, 3, 1, 0); send("R2_claimed");
    src(20, 3, 0, 0); send("R2_not_pending");
    // R3: highest priority wins regardless of position
    clear_all(); src(2, 3, 1, 0); src(17, 11, 1, 0); src(25, 6, 1, 0); send("R3_max");
    // R4: ties go to lower id, within and across subtrees
    clear_all(); src(5, 7, 1, 0); src(9, 7, 1, 0); send("R4_tie_5_9");
    clear_all(); src(27, 4, 1, 0); src(1, 4, 1, 0); send("R4_tie_1_27");
    src(16, 4, 1, 0); send("R4_tie_three");
    // R5: priority-0 source never eligible
    clear_all(); src(3, 0, 1, 0); send("R5_only_zero");
    src(30, 0, 0, 0); src(12, 1, 1, 0); send("R5_zero_vs_one");
    // R6: slots at or above NUM_SRC ignored
    clear_all(); src(30, 15, 1, 0); src(28, 14, 1, 0); src(3, 1, 1, 0); send("R6_out_of_range");
    clear_all(); src(31, 15, 1, 0); send("R6_only_high");
    src(27, 2, 1, 0); send("R6_edge_27");
    // R7: threshold gating
    clear_all(); src(10, 6, 1, 0); st_thr = 4'd6; send("R7_equal");
    st_thr = 4'd5; send("R7_below");
    st_thr = 4'd15; src(11, 15, 1, 0); send("R7_max_thr");
    st_thr = 4'd0; send("R7_zero_thr");
    // Random mixes with few priority levels to force ties
    for (int n = 0; n < 40; n++) begin
      clear_all();
      for (int s = 0; s < MAX_SRC; s++)
        src(s, int'($urandom_range(0, 3)) * 5, $urandom_range(0, 1) == 1,
            $urandom_range(0, 3) == 0);
      st_thr = PW'($urandom_range(0, 15));
      send("R3_R4_R7_random");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule